// File: doc/BRIEF.md
# PHY Management Register Emulator

This block stands in for an Ethernet PHY's management register set, seen by a MAC through a single 32-bit management frame register. Software writes one word that encodes an operation (read or write), a 10-bit register address and 16 bits of data. The block decodes the word and applies it to a small bank of PHY registers. On a read, the register value is returned in the low half of the frame register. Each accepted frame produces a one-cycle completion pulse, which stands in for the MAC's management-complete event.

A level input carries the current link state. Any change of that level, and the first cycle after any reset, counts as a link event. A link event updates the link bits of the status register and latches bits into an interrupt source register. Reading that register clears it. A mask register gates the latched bits onto a registered interrupt output. The block does not model the serial pin-level management protocol, autonegotiation or any analog behaviour.

Top module: `phy_mgmt_emu`

## Requirements
- R1: Frame word layout: bit 29 = 1 selects a read and bit 29 = 0 selects a write; bits 27:18 hold the register address; bits 15:0 hold the write data. On the cycle after `frame_we`, `frame_rdata` holds the written word. For a read, bits 15:0 are replaced by the register value and bits 31:16 keep the written value. `frame_done` is high in exactly the cycle after each cycle in which `frame_we` is high, and low otherwise.
- R2: After reset, register 0 (control) reads 0x3000, register 1 (status) reads 0x7809, register 4 (advertisement) reads 0x01E1, and register 30 (interrupt mask) reads 0. The interrupt source register holds 0 until the first link event. The outputs `frame_rdata`, `frame_done` and `phy_irq` are 0 during reset.
- R3: Registers 2, 3, 5 and 6 read as the constants 0x0007, 0xC0D1, 0x0F71 and 0x0001. Writes to them have no effect.
- R4: A write to register 0 with bit 15 clear stores `data & 0x7980`. If data bit 12 is set, the write also sets status bit 5. A write to register 0 with bit 15 set returns every PHY register to its R2 value, and the next cycle is treated as a link event.
- R5: A write to register 4 stores `(data & 0x2D7F) | 0x0080`.
- R6: A write to register 30 stores `data & 0x00FF` as the interrupt mask. `phy_irq` is high in a cycle exactly when the interrupt source and mask registers, as they stood after the previous clock edge, have a common set bit.
- R7: Reading register 29 returns the latched interrupt bits in bits 7:0 and clears them. If a link event happens in the same cycle, its bits are still latched.
- R8: A link event is a change of `link_up`, or the first cycle after a reset. On a link event with `link_up` high, status bits 5 and 2 (mask 0x0024) are set and interrupt bits 7 and 6 are latched. With `link_up` low, those status bits are cleared and interrupt bit 4 is latched.
- R9: Register 1, registers 7 to 28, register 31 and addresses 32 to 1023 ignore writes. All of these except register 1 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_we | input | 1 | Write strobe for the management frame register |
| frame_wdata | input | 32 | Management frame word |
| link_up | input | 1 | Current link state level |
| frame_rdata | output | 32 | Frame register contents (read result in bits 15:0) |
| frame_done | output | 1 | One-cycle completion pulse for each frame |
| phy_irq | output | 1 | Masked PHY interrupt |

## Verification
The assertions check, on every cycle, the invariants of the write-masked control and advertisement registers. They also check the status and interrupt bits that follow each link event, the clearing of the interrupt source on a read, the stability of every register after an ignored write, the completion-pulse timing, and the one-cycle lag of the interrupt output. Only the bench scenarios can show the values returned by reads. These include the reset values, the constant registers, the upper frame bits that pass through unchanged, a soft reset followed by the link being latched again, and a long random mix of frames and link toggles compared against a reference model.

// File: rtl/phymgmt_pkg.sv
package phymgmt_pkg;

    localparam int FRAME_W  = 32;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 10;
    localparam int INT_W    = 8;
    localparam int OP_BIT   = 29;
    localparam int ADDR_LSB = 18;
    localparam int REG_SPAN = 32;

    localparam logic [ADDR_W-1:0] RA_CTRL    = 10'd0;
    localparam logic [ADDR_W-1:0] RA_STAT    = 10'd1;
    localparam logic [ADDR_W-1:0] RA_IDH     = 10'd2;
    localparam logic [ADDR_W-1:0] RA_IDL     = 10'd3;
    localparam logic [ADDR_W-1:0] RA_ADV     = 10'd4;
    localparam logic [ADDR_W-1:0] RA_LPA     = 10'd5;
    localparam logic [ADDR_W-1:0] RA_EXP     = 10'd6;
    localparam logic [ADDR_W-1:0] RA_INTSRC  = 10'd29;
    localparam logic [ADDR_W-1:0] RA_INTMSK  = 10'd30;

    localparam logic [DATA_W-1:0] CTRL_INIT  = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_INIT  = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_INIT   = 16'h01E1;
    localparam logic [DATA_W-1:0] CTRL_KEEP  = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_KEEP   = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;
    localparam logic [DATA_W-1:0] STAT_LINK  = 16'h0024;
    localparam logic [DATA_W-1:0] STAT_ANEG  = 16'h0020;

    localparam int CTRL_RST_BIT  = 15;
    localparam int CTRL_ANEG_BIT = 12;

    localparam logic [INT_W-1:0] IRQ_UP_BITS   = 8'hC0;
    localparam logic [INT_W-1:0] IRQ_DOWN_BITS = 8'h10;

    typedef struct packed {
        logic              valid;
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mgmt_op_t;

    function automatic logic [DATA_W-1:0] fixed_reg_value(input logic [ADDR_W-1:0] a);
        case (a)
            RA_IDH:  return 16'h0007;
            RA_IDL:  return 16'hC0D1;
            RA_LPA:  return 16'h0F71;
            RA_EXP:  return 16'h0001;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
    import phymgmt_pkg::*;
(
    input  logic               valid,
    input  logic [FRAME_W-1:0] word,
    output mgmt_op_t           op
);
    always_comb begin
        op.valid   = valid;
        op.is_read = word[OP_BIT];
        op.addr    = word[ADDR_LSB +: ADDR_W];
        op.data    = word[DATA_W-1:0];
    end
endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
    import phymgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mgmt_op_t          op,
    input  logic              link_up,
    output logic [DATA_W-1:0] rd_data,
    output logic [INT_W-1:0]  int_bits,
    output logic [INT_W-1:0]  int_mask
);
    logic [DATA_W-1:0] ctrl_q, stat_q, adv_q;
    logic [DATA_W-1:0] ctrl_n, stat_n, adv_n;
    logic [INT_W-1:0]  int_q, mask_q, int_n, mask_n;
    logic              known_q, known_n, prev_q;
    logic              wr, rd, soft_rst, link_evt, rd_int;

    assign wr       = op.valid && !op.is_read;
    assign rd       = op.valid && op.is_read;
    assign soft_rst = wr && (op.addr == RA_CTRL) && op.data[CTRL_RST_BIT];
    assign rd_int   = rd && (op.addr == RA_INTSRC);
    assign link_evt = !known_q || (link_up != prev_q);

    always_comb begin
        if (op.addr >= ADDR_W'(REG_SPAN)) begin
            rd_data = '0;
        end else begin
            case (op.addr)
                RA_CTRL:   rd_data = ctrl_q;
                RA_STAT:   rd_data = stat_q;
                RA_ADV:    rd_data = adv_q;
                RA_INTSRC: rd_data = {{(DATA_W-INT_W){1'b0}}, int_q};
                RA_INTMSK: rd_data = {{(DATA_W-INT_W){1'b0}}, mask_q};
                default:   rd_data = fixed_reg_value(op.addr);
            endcase
        end
    end

    always_comb begin
        ctrl_n  = ctrl_q;
        stat_n  = stat_q;
        adv_n   = adv_q;
        int_n   = int_q;
        mask_n  = mask_q;
        known_n = 1'b1;
        if (soft_rst) begin
            ctrl_n  = CTRL_INIT;
            stat_n  = STAT_INIT;
            adv_n   = ADV_INIT;
            int_n   = '0;
            mask_n  = '0;
            known_n = 1'b0;
        end else begin
            if (wr) begin
                case (op.addr)
                    RA_CTRL: begin
                        ctrl_n = op.data & CTRL_KEEP;
                        if (op.data[CTRL_ANEG_BIT]) stat_n = stat_n | STAT_ANEG;
                    end
                    RA_ADV:    adv_n  = (op.data & ADV_KEEP) | ADV_FORCE;
                    RA_INTMSK: mask_n = op.data[INT_W-1:0];
                    default: ;
                endcase
            end
            if (rd_int) int_n = '0;
            if (link_evt) begin
                if (link_up) begin
                    stat_n = stat_n | STAT_LINK;
                    int_n  = int_n | IRQ_UP_BITS;
                end else begin
                    stat_n = stat_n & ~STAT_LINK;
                    int_n  = int_n | IRQ_DOWN_BITS;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_INIT;
            stat_q  <= STAT_INIT;
            adv_q   <= ADV_INIT;
            int_q   <= '0;
            mask_q  <= '0;
            known_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_n;
            stat_q  <= stat_n;
            adv_q   <= adv_n;
            int_q   <= int_n;
            mask_q  <= mask_n;
            known_q <= known_n;
            prev_q  <= link_up;
        end
    end

    assign int_bits = int_q;
    assign int_mask = mask_q;

    // R8
    a_r8_link_up_latch: assert property (@(posedge clk) disable iff (rst)
        (link_evt && link_up && !soft_rst) |=>
            ((stat_q & STAT_LINK) == STAT_LINK) && int_q[7] && int_q[6]);
    // R8
    a_r8_link_down_latch: assert property (@(posedge clk) disable iff (rst)
        (link_evt && !link_up && !soft_rst) |=>
            ((stat_q & STAT_LINK) == '0) && int_q[4]);
    // R7
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (rd_int && !link_evt) |=> (int_q == '0));
    // R4
    a_r4_ctrl_masked: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q & ~CTRL_KEEP) == '0));
    // R5
    a_r5_adv_masked: assert property (@(posedge clk) disable iff (rst)
        adv_q[7] && ((adv_q & ~(ADV_KEEP | ADV_FORCE)) == '0));
    // R9
    a_r9_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr && !link_evt && op.addr != RA_CTRL && op.addr != RA_ADV &&
         op.addr != RA_INTMSK) |=>
            $stable(ctrl_q) && $stable(stat_q) && $stable(adv_q) &&
            $stable(mask_q) && $stable(int_q));
endmodule

// File: rtl/phy_irq_gen.sv
module phy_irq_gen
    import phymgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] int_bits,
    input  logic [INT_W-1:0] int_mask,
    output logic             irq
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(int_bits & int_mask);
    end

    assign irq = irq_q;

    // R6
    a_r6_irq_lag: assert property (@(posedge clk) disable iff (rst)
        ((int_bits & int_mask) == '0) |=> !irq);
endmodule

// File: rtl/phy_mgmt_emu.sv
module phy_mgmt_emu
    import phymgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_we,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               link_up,
    output logic [FRAME_W-1:0] frame_rdata,
    output logic               frame_done,
    output logic               phy_irq
);
    mgmt_op_t          op;
    logic [DATA_W-1:0] rd_data;
    logic [INT_W-1:0]  int_bits, int_mask;
    logic [FRAME_W-1:0] frame_q;
    logic              done_q;

    mgmt_frame_decode u_decode (
        .valid (frame_we),
        .word  (frame_wdata),
        .op    (op)
    );

    phy_reg_bank u_regs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .link_up  (link_up),
        .rd_data  (rd_data),
        .int_bits (int_bits),
        .int_mask (int_mask)
    );

    phy_irq_gen u_irq (
        .clk      (clk),
        .rst      (rst),
        .int_bits (int_bits),
        .int_mask (int_mask),
        .irq      (phy_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= op.valid;
            if (op.valid) begin
                if (op.is_read) frame_q <= {frame_wdata[FRAME_W-1:DATA_W], rd_data};
                else            frame_q <= frame_wdata;
            end
        end
    end

    assign frame_rdata = frame_q;
    assign frame_done  = done_q;

    // R1
    a_r1_done_after_we: assert property (@(posedge clk) disable iff (rst)
        frame_we |=> frame_done);
    // R1
    a_r1_done_only_after_we: assert property (@(posedge clk) disable iff (rst)
        !frame_we |=> !frame_done);
    // R1
    a_r1_write_echo: assert property (@(posedge clk) disable iff (rst)
        (frame_we && !frame_wdata[OP_BIT]) |=> (frame_rdata == $past(frame_wdata)));
endmodule

// File: tb/test_phy_mgmt_emu.sv
module test_phy_mgmt_emu;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_we;
    logic [31:0] frame_wdata;
    logic        link_up;
    logic [31:0] frame_rdata;
    logic        frame_done;
    logic        phy_irq;

    int checks = 0;
    int errors = 0;
    bit lk = 1'b1;

    logic [15:0] m_ctrl, m_stat, m_adv;
    logic [7:0]  m_int, m_mask;
    bit          m_known, m_prev;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_mgmt_emu i_phy_mgmt_emu (
        .clk(clk), .rst(rst), .frame_we(frame_we), .frame_wdata(frame_wdata),
        .link_up(link_up), .frame_rdata(frame_rdata), .frame_done(frame_done),
        .phy_irq(phy_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
        m_int = 8'h00; m_mask = 8'h00;
    endtask

    function automatic logic [15:0] model_read(input logic [9:0] a);
        if (a > 10'd31) return 16'h0;
        case (a)
            10'd0:  return m_ctrl;
            10'd1:  return m_stat;
            10'd2:  return 16'h0007;
            10'd3:  return 16'hC0D1;
            10'd4:  return m_adv;
            10'd5:  return 16'h0F71;
            10'd6:  return 16'h0001;
            10'd29: return {8'h00, m_int};
            10'd30: return {8'h00, m_mask};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_for(input logic [9:0] a);
        case (a)
            10'd0: return "R4";
            10'd1: return "R8";
            10'd2, 10'd3, 10'd5, 10'd6: return "R3";
            10'd4: return "R5";
            10'd29: return "R7";
            10'd30: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic model_step(input bit we, input logic [31:0] w, input bit l,
                              output logic [15:0] rdv);
        bit          isr = w[29];
        logic [9:0]  a   = w[27:18];
        logic [15:0] d   = w[15:0];
        bit          evt = !m_known || (l != m_prev);
        rdv = model_read(a);
        m_prev = l;
        if (we && !isr && a == 10'd0 && d[15]) begin
            model_reset();
            m_known = 1'b0;
        end else begin
            if (we && !isr) begin
                if (a == 10'd0) begin
                    m_ctrl = d & 16'h7980;
                    if (d[12]) m_stat = m_stat | 16'h0020;
                end else if (a == 10'd4) begin
                    m_adv = (d & 16'h2D7F) | 16'h0080;
                end else if (a == 10'd30) begin
                    m_mask = d[7:0];
                end
            end
            if (we && isr && a == 10'd29) m_int = 8'h00;
            if (evt) begin
                if (l) begin m_stat = m_stat | 16'h0024; m_int = m_int | 8'hC0; end
                else   begin m_stat = m_stat & ~16'h0024; m_int = m_int | 8'h10; end
            end
            m_known = 1'b1;
        end
    endtask

    // Starts and ends at a falling edge; one rising edge in between.
    task automatic run_cycle(input bit we, input logic [31:0] w, input string tag);
        logic [15:0] rdv;
        bit          exp_irq;
        string       t;
        frame_we = we; frame_wdata = w; link_up = lk;
        exp_irq = |(m_int & m_mask);
        model_step(we, w, lk, rdv);
        @(posedge clk);
        @(negedge clk);
        chk("R1 done", {31'b0, frame_done}, {31'b0, we});
        chk("R6 irq", {31'b0, phy_irq}, {31'b0, exp_irq});
        if (we) begin
            t = (tag == "") ? tag_for(w[27:18]) : tag;
            if (w[29]) chk({t, " read"}, frame_rdata, {w[31:16], rdv});
            else       chk("R1 write echo", frame_rdata, w);
        end
    endtask

    function automatic logic [31:0] mk(input bit r, input int a, input logic [15:0] d);
        return {2'b01, r, 1'b0, 10'(a), 2'b10, d};
    endfunction

    task automatic rd_reg(input int a, input string tag);
        run_cycle(1'b1, mk(1'b1, a, 16'hABCD), tag);
    endtask

    task automatic wr_reg(input int a, input logic [15:0] d);
        run_cycle(1'b1, mk(1'b0, a, d), "");
    endtask

    task automatic idle();
        run_cycle(1'b0, 32'h0, "");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; frame_we = 1'b0; frame_wdata = '0; link_up = 1'b1;
        model_reset(); m_known = 1'b0; m_prev = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 reset frame", frame_rdata, 32'h0);
        chk("R2 reset done", {31'b0, frame_done}, 32'h0);
        chk("R2 reset irq", {31'b0, phy_irq}, 32'h0);
        rst = 1'b0;

        // Reset values; first cycle also latches link (R8)
        rd_reg(1, "R2");
        rd_reg(0, "R2");
        rd_reg(4, "R2");
        rd_reg(30, "R2");
        rd_reg(29, "R8");
        rd_reg(29, "R7");
        // Advertisement masking
        wr_reg(4, 16'hFFFF); rd_reg(4, "R5");
        wr_reg(4, 16'h0000); rd_reg(4, "R5");
        // Link down, then autoneg enable sets status bit 5
        lk = 1'b0; idle();
        rd_reg(1, "R8");
        wr_reg(0, 16'h1000); rd_reg(1, "R4"); rd_reg(0, "R4");
        wr_reg(0, 16'h7FFF); rd_reg(0, "R4");
        // Mask and interrupt output
        wr_reg(30, 16'h0110); idle(); idle();
        rd_reg(30, "R6");
        rd_reg(29, "R7"); idle(); idle();
        // Read-clear racing a link event
        lk = 1'b1; rd_reg(29, "R7"); rd_reg(29, "R7");
        // Ignored writes and constants
        wr_reg(1, 16'hFFFF); rd_reg(1, "R9");
        wr_reg(2, 16'h0000); rd_reg(2, "R3");
        rd_reg(3, "R3"); rd_reg(5, "R3"); rd_reg(6, "R3");
        wr_reg(17, 16'h1234); rd_reg(17, "R9");
        rd_reg(40, "R9"); rd_reg(1023, "R9"); rd_reg(31, "R9");
        // Soft reset then relatch of link
        wr_reg(30, 16'h00FF);
        wr_reg(0, 16'h8000);
        rd_reg(4, "R4"); rd_reg(30, "R4"); rd_reg(29, "R4"); idle();

        // Random mix
        for (int i = 0; i < 600; i++) begin
            int          a;
            bit          we, r;
            logic [31:0] w;
            logic [15:0] d;
            case ($urandom % 13)
                0: a = 0;  1: a = 1;  2: a = 2;  3: a = 3;  4: a = 4;
                5: a = 5;  6: a = 6;  7: a = 29; 8: a = 30; 9: a = 17;
                10: a = 31; 11: a = 40 + ($urandom % 900); default: a = 29;
            endcase
            if (($urandom % 16) == 0) lk = ~lk;
            we = (($urandom % 4) != 0);
            r  = $urandom % 2;
            d  = 16'($urandom);
            if (a == 0 && (($urandom % 8) != 0)) d[15] = 1'b0;
            w = $urandom;
            w[29] = r;
            w[27:18] = 10'(a);
            w[15:0] = d;
            run_cycle(we, w, "");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule